// File: doc/BRIEF.md
# Addend-Tuned Time-of-Day Counter

This block holds a 64-bit time-of-day value that every timestamp and event function of the chip reads as its one time source. The counter does not move by a fixed step. On every reference clock cycle a 32-bit rate word (the addend) is summed into a 32-bit phase accumulator. Each carry out of that accumulator adds one to the time value. The addend therefore sets the effective count frequency as a fraction of the reference clock, and a software servo trims that fraction.

Besides setting the addend, the host has two more controls. It can force the time to an absolute 64-bit value, or it can step the time by a signed amount. The host reads the time through two 32-bit words. Reading the low word latches the upper half of the same time value into a holding register, so the two halves read in sequence always belong together.

Top module: `tod_counter`

## Requirements
- R1: After reset the time value, the addend and the latched high word are all zero.
- R2: Every cycle the phase accumulator adds the addend modulo 2^32 and never saturates. The time value increases by exactly one in the cycle after each carry out of the accumulator, and holds otherwise.
- R3: A write on `rate_wr` loads `rate_wdata` as the addend. The cycle of the write still accumulates the previous addend, and the new value is used from the following cycle on.
- R4: While the addend is zero the time value does not change unless it is loaded or stepped.
- R5: A pulse on `set_wr` makes the time equal to `set_value` on the next cycle. The set wins over that cycle's carry increment and over a step in the same cycle. The phase accumulator keeps running across a set.
- R6: A pulse on `step_wr` adds `step_value`, read as a two's-complement signed number, to the time. Any carry increment of the same cycle is also added, so the time changes by step plus carry.
- R7: `rd_lo_data` is always the lower 32 bits of the current time. A pulse on `rd_lo` copies the upper 32 bits of the current time into `rd_hi_data`. `rd_hi_data` holds that copy until the next pulse.
- R8: The time value wraps from all ones to zero modulo 2^64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_wr | input | 1 | Addend write strobe |
| rate_wdata | input | 32 | New addend value |
| set_wr | input | 1 | Absolute time load strobe |
| set_value | input | 64 | Time value to load |
| step_wr | input | 1 | Signed step strobe |
| step_value | input | 64 | Signed step amount, two's complement |
| rd_lo | input | 1 | Low-word read strobe that latches the high word |
| time_now | output | 64 | Current time for timestamp and event logic |
| rd_lo_data | output | 32 | Low word of the current time |
| rd_hi_data | output | 32 | High word latched at the last low-word read |

## Verification
The assertions check on every cycle the rules that hold for any input. The time moves by zero or one when it is not set or stepped. A set lands exactly on the next cycle. A step moves the time by the step plus zero or one. A zero addend never produces a carry. The latched high word changes only on a low-word read. Other behaviours depend on particular stimulus, and only the bench scenarios, compared against a behavioural model, can show them. These are the exact carry cadence for chosen addends, the one-cycle delay before a new addend takes effect, a set colliding with a carry and a step, negative steps, and the wrap of the time value through all ones.

// File: rtl/tod_pkg.sv
package tod_pkg;
   localparam int unsigned TOD_TIME_W  = 64;
   localparam int unsigned TOD_PHASE_W = 32;
   localparam int unsigned TOD_RD_W    = 32;

   typedef enum logic [1:0] {
      TOD_HOLD = 2'd0,
      TOD_TICK = 2'd1,
      TOD_STEP = 2'd2,
      TOD_SET  = 2'd3
   } tod_update_e;
endpackage

// File: rtl/tod_phase_acc.sv
module tod_phase_acc #(
   parameter int unsigned PHASE_W = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rate_wr,
   input  logic [PHASE_W-1:0] rate_wdata,
   output logic               carry
);
   localparam int unsigned SUM_W = PHASE_W + 1;

   if (PHASE_W < 2) begin : g_bad_width
      $error("tod_phase_acc: PHASE_W must be at least 2");
   end

   logic [PHASE_W-1:0] addend_q;
   logic [PHASE_W-1:0] phase_q;
   logic [SUM_W-1:0]   sum;

   always_comb begin
      sum   = {1'b0, phase_q} + {1'b0, addend_q};
      carry = sum[SUM_W-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addend_q <= '0;
         phase_q  <= '0;
      end else begin
         phase_q <= sum[PHASE_W-1:0];
         if (rate_wr) begin
            addend_q <= rate_wdata;
         end
      end
   end

   // A zero rate word must never overflow the phase accumulator.
   p_freeze_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (addend_q == '0) |-> !carry);

   // The new rate word is in the register one cycle after its write.
   p_rate_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rate_wr |=> (addend_q == $past(rate_wdata)));
endmodule

// File: rtl/tod_time_reg.sv
module tod_time_reg
   import tod_pkg::*;
#(
   parameter int unsigned TIME_W = 64,
   parameter bit          STEP_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              carry,
   input  logic              set_wr,
   input  logic [TIME_W-1:0] set_value,
   input  logic              step_wr,
   input  logic [TIME_W-1:0] step_value,
   output logic [TIME_W-1:0] time_q
);
   if (TIME_W < 8) begin : g_bad_width
      $error("tod_time_reg: TIME_W must be at least 8");
   end

   logic [TIME_W-1:0] step_term;
   tod_update_e       kind;
   logic [TIME_W-1:0] time_d;

   if (STEP_EN) begin : g_step
      assign step_term = step_wr ? step_value : '0;
   end else begin : g_no_step
      logic unused_step;
      assign unused_step = step_wr ^ (^step_value);
      assign step_term   = '0;
   end

   always_comb begin
      if (set_wr)                   kind = TOD_SET;
      else if (STEP_EN && step_wr)  kind = TOD_STEP;
      else if (carry)               kind = TOD_TICK;
      else                          kind = TOD_HOLD;
   end

   always_comb begin
      unique case (kind)
         TOD_SET:  time_d = set_value;
         TOD_STEP: time_d = time_q + step_term + TIME_W'(carry);
         TOD_TICK: time_d = time_q + TIME_W'(1);
         default:  time_d = time_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) time_q <= '0;
      else        time_q <= time_d;
   end

   p_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
      set_wr |=> (time_q == $past(set_value)));

   p_step_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_wr && !step_wr) |=>
         ((time_q == $past(time_q)) || (time_q == $past(time_q) + TIME_W'(1))));

   if (STEP_EN) begin : g_step_chk
      p_step_sum_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (!set_wr && step_wr) |=>
            ((time_q - $past(time_q) - $past(step_value) == '0) ||
             (time_q - $past(time_q) - $past(step_value) == TIME_W'(1))));
   end
endmodule

// File: rtl/tod_read_snap.sv
module tod_read_snap #(
   parameter int unsigned TIME_W = 64,
   parameter int unsigned RD_W   = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_lo,
   input  logic [TIME_W-1:0] time_q,
   output logic [RD_W-1:0]   rd_lo_data,
   output logic [RD_W-1:0]   rd_hi_data
);
   localparam int unsigned HI_LSB = RD_W;

   if (TIME_W != 2 * RD_W) begin : g_bad_split
      $error("tod_read_snap: TIME_W must be twice RD_W");
   end

   logic [RD_W-1:0] hi_q;

   assign rd_lo_data = time_q[RD_W-1:0];
   assign rd_hi_data = hi_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     hi_q <= '0;
      else if (rd_lo) hi_q <= time_q[TIME_W-1:HI_LSB];
   end

   p_snap_take_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_lo |=> (rd_hi_data == $past(time_q[TIME_W-1:HI_LSB])));

   p_snap_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_lo |=> $stable(rd_hi_data));
endmodule

// File: rtl/tod_counter.sv
module tod_counter
   import tod_pkg::*;
#(
   parameter int unsigned TIME_W  = TOD_TIME_W,
   parameter int unsigned PHASE_W = TOD_PHASE_W,
   parameter int unsigned RD_W    = TOD_RD_W,
   parameter bit          STEP_EN = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rate_wr,
   input  logic [PHASE_W-1:0] rate_wdata,
   input  logic               set_wr,
   input  logic [TIME_W-1:0]  set_value,
   input  logic               step_wr,
   input  logic [TIME_W-1:0]  step_value,
   input  logic               rd_lo,
   output logic [TIME_W-1:0]  time_now,
   output logic [RD_W-1:0]    rd_lo_data,
   output logic [RD_W-1:0]    rd_hi_data
);
   if (PHASE_W > TIME_W) begin : g_bad_ratio
      $error("tod_counter: PHASE_W must not exceed TIME_W");
   end

   logic carry;

   tod_phase_acc #(.PHASE_W(PHASE_W)) u_phase (
      .clk(clk), .rst_n(rst_n), .rate_wr(rate_wr),
      .rate_wdata(rate_wdata), .carry(carry)
   );

   tod_time_reg #(.TIME_W(TIME_W), .STEP_EN(STEP_EN)) u_time (
      .clk(clk), .rst_n(rst_n), .carry(carry),
      .set_wr(set_wr), .set_value(set_value),
      .step_wr(step_wr), .step_value(step_value), .time_q(time_now)
   );

   tod_read_snap #(.TIME_W(TIME_W), .RD_W(RD_W)) u_snap (
      .clk(clk), .rst_n(rst_n), .rd_lo(rd_lo), .time_q(time_now),
      .rd_lo_data(rd_lo_data), .rd_hi_data(rd_hi_data)
   );

   p_reset_r1: assert property (@(posedge clk)
      !rst_n |=> (time_now == '0 || !rst_n));
endmodule

// File: tb/tb_tod_counter.sv
module tb_tod_counter;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rate_wr = 1'b0;
   logic [31:0] rate_wdata = '0;
   logic        set_wr = 1'b0;
   logic [63:0] set_value = '0;
   logic        step_wr = 1'b0;
   logic [63:0] step_value = '0;
   logic        rd_lo = 1'b0;
   logic [63:0] time_now;
   logic [31:0] rd_lo_data;
   logic [31:0] rd_hi_data;

   int errors = 0;
   int checks = 0;
   string cur_req = "R1";
   bit done = 1'b0;

   longint unsigned m_time = 0;
   longint unsigned m_phase = 0;
   longint unsigned m_addend = 0;
   longint unsigned m_snap = 0;

   always #4 clk = ~clk;

   tod_counter dut (
      .clk(clk), .rst_n(rst_n), .rate_wr(rate_wr), .rate_wdata(rate_wdata),
      .set_wr(set_wr), .set_value(set_value), .step_wr(step_wr),
      .step_value(step_value), .rd_lo(rd_lo), .time_now(time_now),
      .rd_lo_data(rd_lo_data), .rd_hi_data(rd_hi_data)
   );

   // Behavioural reference model, updated on each rising edge.
   always @(posedge clk) begin
      longint unsigned s;
      longint unsigned c;
      if (!rst_n) begin
         m_time = 0; m_phase = 0; m_addend = 0; m_snap = 0;
      end else begin
         s = m_phase + m_addend;
         c = s >> 32;
         if (rd_lo) m_snap = m_time >> 32;
         if (set_wr)       m_time = set_value;
         else if (step_wr) m_time = m_time + step_value + c;
         else              m_time = m_time + c;
         m_phase = s & 64'hFFFF_FFFF;
         if (rate_wr) m_addend = {32'd0, rate_wdata};
      end
   end

   task automatic check(input string req, input longint unsigned act,
                        input longint unsigned exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic compare();
      check({cur_req, " time"}, time_now, m_time);
      check({cur_req, " lo"}, {32'd0, rd_lo_data}, m_time & 64'hFFFF_FFFF);
      check({cur_req, " hi"}, {32'd0, rd_hi_data}, m_snap);
   endtask

   task automatic step(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         compare();
      end
   endtask

   initial begin
      // R1: reset state
      cur_req = "R1";
      step(2);
      check("R1 reset time", time_now, 64'd0);
      rst_n = 1'b1;
      step(3);
      check("R1 frozen at zero addend", time_now, 64'd0);

      // R2: half-scale addend ticks every second cycle
      cur_req = "R2";
      rate_wr = 1'b1; rate_wdata = 32'h8000_0000;
      step(1);
      rate_wr = 1'b0;
      step(20);
      check("R2 half rate count", time_now, 64'd10);
      rate_wr = 1'b1; rate_wdata = 32'h5555_5556;
      step(1);
      rate_wr = 1'b0;
      step(30);
      rate_wr = 1'b1; rate_wdata = 32'hFFFF_FFFF;
      step(1);
      rate_wr = 1'b0;
      step(10);

      // R3: change of addend takes effect one cycle late
      cur_req = "R3";
      rate_wr = 1'b1; rate_wdata = 32'h4000_0000;
      step(1);
      rate_wr = 1'b1; rate_wdata = 32'hC000_0000;
      step(1);
      rate_wr = 1'b0;
      step(8);

      // R4: zero addend freezes time
      cur_req = "R4";
      rate_wr = 1'b1; rate_wdata = 32'd0;
      step(1);
      rate_wr = 1'b0;
      step(2);
      set_value = time_now;
      step(15);
      check("R4 frozen", time_now, set_value);

      // R5: set wins over carry and step; phase keeps running
      cur_req = "R5";
      rate_wr = 1'b1; rate_wdata = 32'hFFFF_FFFF;
      step(1);
      rate_wr = 1'b0;
      set_wr = 1'b1; set_value = 64'h0123_4567_89AB_CDEF;
      step_wr = 1'b1; step_value = 64'd1000;
      step(1);
      set_wr = 1'b0; step_wr = 1'b0;
      check("R5 set value", time_now, 64'h0123_4567_89AB_CDEF);
      step(6);

      // R6: signed steps, positive and negative, with carry
      cur_req = "R6";
      step_wr = 1'b1; step_value = 64'd500;
      step(1);
      step_value = -64'sd777;
      step(1);
      step_wr = 1'b0;
      rate_wr = 1'b1; rate_wdata = 32'd0;
      step(1);
      rate_wr = 1'b0;
      step(2);
      set_value = time_now;
      step_wr = 1'b1; step_value = -64'sd3;
      step(1);
      step_wr = 1'b0;
      check("R6 negative step no carry", time_now, set_value - 64'd3);
      step(2);

      // R7: coherent split read
      cur_req = "R7";
      set_wr = 1'b1; set_value = 64'hAAAA_0001_FFFF_FFFE;
      rate_wr = 1'b1; rate_wdata = 32'hFFFF_FFFF;
      step(1);
      set_wr = 1'b0; rate_wr = 1'b0;
      step(1);
      rd_lo = 1'b1;
      step(1);
      rd_lo = 1'b0;
      step(6);
      check("R7 hi held", {32'd0, rd_hi_data}, 64'hAAAA_0001);
      rd_lo = 1'b1;
      step(1);
      rd_lo = 1'b0;
      step(2);

      // R8: wrap through all ones
      cur_req = "R8";
      set_wr = 1'b1; set_value = 64'hFFFF_FFFF_FFFF_FFFD;
      step(1);
      set_wr = 1'b0;
      step(8);
      step_wr = 1'b1; step_value = 64'hFFFF_FFFF_FFFF_FFF0;
      step(1);
      step_wr = 1'b0;
      step(4);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog act=hung exp=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule